// File: doc/BRIEF.md
# Compare-Output Waveform Generator

This block produces the level of one output-compare pin for an 8-bit timer. It watches the timer's count value, count direction and end-of-range events, and compares the count with this channel's compare register. A two-bit output-action field and a three-bit waveform-mode field set what a match does to the pin. The waveform mode also sets what happens at the end of the range. Three families are supported:

- Non-PWM, either free-running or clear-on-match.
- Single-slope (fast) PWM.
- Dual-slope (phase-correct) PWM.

The block also reports whether the pin has been taken from the ordinary port logic. It reports separately whether the pin's output driver should be on, which additionally needs the pin's direction bit.

The timer itself lives outside this block. A counter feeds it the value `cnt` and a `tick` strobe in each cycle the counter advances. The counter also gives:

- the direction, on `cnt_down`;
- a pulse while it holds its TOP value, on `evt_top`;
- in single-slope PWM, a pulse in the cycle before it returns to zero, on `evt_wrap`.

TOP is 0xFF, or the value of compare register A (`ocr_a`) when waveform-mode bit 2 is set. The parameter `CHAN_A` marks the instance that serves channel A.

Top module: `cmp_wave_gen`

## Requirements
- R1: After reset, `pin_val` is 0.
- R2: `pin_ovr` is 1 when `act` is 2 or 3. When `act` is 1, `pin_ovr` is 1 in the non-PWM modes, and 1 in the PWM modes only if `CHAN_A`=1 and `wmode[2]`=1. Otherwise `pin_ovr` is 0. `pin_oe` equals `pin_ovr` AND `ddr`.
- R3: The non-PWM modes are `wmode` 000 and 010 (and 100, 110). In these modes, `act`=1 inverts `pin_val` one clock after a cycle with `tick`=1 and `cnt`=`ocr`.
- R4: In the non-PWM modes, `act`=2 clears `pin_val` one clock after a match. `act`=3 sets it one clock after a match.
- R5: Fast PWM is `wmode` 011, with TOP fixed at 0xFF, or 111, with TOP equal to `ocr_a`. In fast PWM, `act`=2 clears the pin on a match and sets it on `evt_wrap`. `act`=3 does the reverse.
- R6: In fast PWM, if a match and `evt_wrap` fall in the same cycle, the wrap action wins. With `ocr`=0 and `act`=2, the pin is high for exactly one cycle per period.
- R7: In fast PWM with `act[1]`=1 and `ocr` equal to TOP, a match does not change the pin. The pin is set or cleared only by the wrap action.
- R8: Phase-correct PWM is `wmode` 001, with TOP fixed at 0xFF, or 101, with TOP equal to `ocr_a`. In phase-correct PWM, `act`=2 clears the pin on a match while `cnt_down`=0 and sets it on a match while `cnt_down`=1. `act`=3 does the reverse.
- R9: In phase-correct PWM with `act[1]`=1 and `ocr` equal to TOP, the match is ignored. At `evt_top` the pin takes the level of the counting-down action: 1 for `act`=2 and 0 for `act`=3.
- R10: In a PWM mode with `act`=1, the pin toggles on each match if `CHAN_A`=1 and `wmode[2]`=1. Otherwise the pin is disconnected and holds its level.
- R11: A cycle with `tick`=0, `evt_top`=0 and `evt_wrap`=0 leaves `pin_val` unchanged, even if `cnt` equals `ocr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advanced this cycle; qualifies compare match |
| cnt | input | 8 | Current counter value |
| cnt_down | input | 1 | 1 while the counter is on its down slope |
| evt_top | input | 1 | Counter holds TOP this cycle |
| evt_wrap | input | 1 | Counter returns to zero on the next tick (single-slope) |
| ocr | input | 8 | This channel's compare value |
| ocr_a | input | 8 | Compare register A, used as TOP when wmode[2]=1 |
| act | input | 2 | Output-action field |
| wmode | input | 3 | Waveform-mode field |
| ddr | input | 1 | Direction bit of the pin |
| pin_val | output | 1 | Registered waveform level |
| pin_ovr | output | 1 | Pin taken from ordinary port logic |
| pin_oe | output | 1 | Output driver enable |

## Verification
The hardest behaviour to reach from the ports is the compare-equals-TOP rule. It only shows up when the compare value sits exactly on the end of the range, with the high action bit set. In the dual-slope mode it also depends on which slope the counter is on. The sweep sets both fixed and register-defined TOP values, and places compare values at zero, one, mid-range and TOP itself. It also runs a second instance as a non-A channel, which separates the channel-A-only toggle.

// File: rtl/cmp_wave_gen.sv
module cmp_wave_gen #(
  parameter int W = 8,
  parameter bit CHAN_A = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         cnt_down,
  input  logic         evt_top,
  input  logic         evt_wrap,
  input  logic [W-1:0] ocr,
  input  logic [W-1:0] ocr_a,
  input  logic [1:0]   act,
  input  logic [2:0]   wmode,
  input  logic         ddr,
  output logic         pin_val,
  output logic         pin_ovr,
  output logic         pin_oe
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  wire is_fast  = (wmode[1:0] == 2'b11);
  wire is_phase = (wmode[1:0] == 2'b01);
  wire is_pwm   = is_fast | is_phase;
  wire [W-1:0] top_v = wmode[2] ? ocr_a : MAXV;

  wire tog_mode  = (act == 2'b01) && (!is_pwm || (CHAN_A && wmode[2]));
  wire match     = tick && (cnt == ocr);
  wire top_case  = is_pwm && act[1] && (ocr == top_v);
  wire eff_match = match && !top_case;

  assign pin_ovr = act[1] | tog_mode;
  assign pin_oe  = pin_ovr & ddr;

  logic nxt;
  always_comb begin
    nxt = pin_val;
    if (tog_mode) begin
      if (match) nxt = ~pin_val;
    end else if (act[1]) begin
      if (!is_pwm) begin
        if (match) nxt = act[0];
      end else if (is_fast) begin
        if (eff_match) nxt = act[0];
        if (evt_wrap)  nxt = ~act[0];
      end else begin
        if (eff_match) nxt = cnt_down ? ~act[0] : act[0];
        if (evt_top && top_case) nxt = ~act[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_val <= 1'b0;
    else        pin_val <= nxt;
  end

  a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> !pin_val);

  a_r2_oe_needs_ddr: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> (ddr && act != 2'b00));

  a_r4_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (wmode == 3'b000 && act == 2'b10 && tick && cnt == ocr) |=> !pin_val);

  a_r6_wrap_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wmode[1:0] == 2'b11 && act == 2'b10 && evt_wrap) |=> pin_val);

  a_r7_fast_top_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wmode[1:0] == 2'b11 && act[1] && ocr == (wmode[2] ? ocr_a : MAXV) && !evt_wrap)
      |=> $stable(pin_val));

  a_r9_phase_top_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wmode[1:0] == 2'b01 && act[1] && ocr == (wmode[2] ? ocr_a : MAXV) && !evt_top)
      |=> $stable(pin_val));

  a_r10_disconnected_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wmode[0] && act == 2'b01 && !(CHAN_A && wmode[2])) |=> $stable(pin_val));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !evt_top && !evt_wrap) |=> $stable(pin_val));

endmodule

// File: tb/cmp_wave_gen_tb.sv
module cmp_wave_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, cnt_down = 1'b0, evt_top = 1'b0, evt_wrap = 1'b0, ddr = 1'b0;
  logic [7:0] cnt = '0, ocr = '0, ocr_a = 8'h20;
  logic [1:0] act = '0;
  logic [2:0] wmode = '0;
  logic pv_a, ov_a, oe_a, pv_b, ov_b, oe_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmp_wave_gen #(.W(8), .CHAN_A(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_down(cnt_down),
    .evt_top(evt_top), .evt_wrap(evt_wrap), .ocr(ocr), .ocr_a(ocr_a),
    .act(act), .wmode(wmode), .ddr(ddr),
    .pin_val(pv_a), .pin_ovr(ov_a), .pin_oe(oe_a));

  cmp_wave_gen #(.W(8), .CHAN_A(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_down(cnt_down),
    .evt_top(evt_top), .evt_wrap(evt_wrap), .ocr(ocr), .ocr_a(ocr_a),
    .act(act), .wmode(wmode), .ddr(ddr),
    .pin_val(pv_b), .pin_ovr(ov_b), .pin_oe(oe_b));

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s wmode=%b act=%b ocr=%0d cnt=%0d dn=%b: got %b expected %b",
               tag, wmode, act, ocr, cnt, cnt_down, got, exp);
    end
  endtask

  function automatic string req_tag(input logic [2:0] wm, input logic [1:0] a,
                                    input logic [7:0] oc, input logic [7:0] tp, input bit ch);
    bit pwm = wm[0];
    if (a == 2'b01) return (pwm ? "R10" : "R3");
    if (!pwm) return "R4";
    if (wm[1]) return (oc == tp) ? "R7" : ((oc == 0) ? "R6" : "R5");
    return (oc == tp) ? "R9" : "R8";
  endfunction

  function automatic logic model(input logic prev, input logic [2:0] wm, input logic [1:0] a,
                                 input logic [7:0] oc, input logic [7:0] tp,
                                 input logic [7:0] v, input logic d, input bit ch);
    bit pwm = wm[0];
    bit tog = (a == 2'b01) && (!pwm || (ch && wm[2]));
    logic lvl;
    if (tog) return prev ^ (v == oc);
    if (!a[1]) return prev;
    if (!pwm) return (v == oc) ? a[0] : prev;
    if (wm[1]) lvl = !(oc != tp && v >= oc && v < tp);
    else if (oc == tp) lvl = 1'b1;
    else lvl = d ? (v <= oc) : (v < oc);
    return lvl ^ a[0];
  endfunction

  task automatic run_combo(input logic [2:0] wm, input logic [1:0] a, input logic [7:0] oc);
    logic [7:0] tp;
    int per;
    logic ea, eb;
    bit pwm = wm[0];
    bit ovr_a, ovr_b;
    tp = (wm[2] || wm == 3'b010) ? ocr_a : 8'hFF;
    per = (wm[1:0] == 2'b01) ? 2 * int'(tp) : int'(tp) + 1;
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; evt_top = 1'b0; evt_wrap = 1'b0;
    wmode = wm; act = a; ocr = oc;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(pv_a, 1'b0, "R1");
    ea = 1'b0; eb = 1'b0;
    ovr_a = a[1] || (a == 2'b01 && (!pwm || wm[2]));
    ovr_b = a[1] || (a == 2'b01 && !pwm);
    for (int s = 0; s < 2 * per; s++) begin
      int p;
      logic [7:0] v;
      logic d;
      p = s % per;
      if (wm[1:0] == 2'b01) begin
        d = (p > int'(tp));
        v = d ? 8'(per - p) : 8'(p);
        evt_top = (p == int'(tp));
        evt_wrap = 1'b0;
      end else begin
        d = 1'b0;
        v = 8'(p);
        evt_top = (v == tp);
        evt_wrap = (v == tp);
      end
      cnt = v; cnt_down = d; tick = 1'b1; ddr = s[0];
      #1;
      if (s < 4) begin
        chk(ov_a, ovr_a, "R2");
        chk(oe_a, ovr_a && ddr, "R2");
        chk(ov_b, ovr_b, "R2");
        chk(oe_b, ovr_b && ddr, "R2");
      end
      @(posedge clk);
      #1;
      ea = model(ea, wm, a, oc, tp, v, d, 1'b1);
      eb = model(eb, wm, a, oc, tp, v, d, 1'b0);
      if (s >= per) begin
        chk(pv_a, ea, req_tag(wm, a, oc, tp, 1'b1));
        chk(pv_b, eb, req_tag(wm, a, oc, tp, 1'b0));
      end
      @(negedge clk);
    end
  endtask

  initial begin
    logic [2:0] wms [6] = '{3'b000, 3'b010, 3'b011, 3'b111, 3'b001, 3'b101};
    logic [7:0] ocs [7] = '{8'h00, 8'h01, 8'h10, 8'h1F, 8'h20, 8'hFE, 8'hFF};
    logic held;
    foreach (wms[i]) begin
      for (int a = 0; a < 4; a++) begin
        foreach (ocs[j]) begin
          logic [7:0] tp;
          tp = (wms[i][2] || wms[i] == 3'b010) ? 8'h20 : 8'hFF;
          if (wms[i][0] && ocs[j] > tp) continue;
          run_combo(wms[i], 2'(a), ocs[j]);
        end
      end
    end
    // R11: no tick while cnt equals ocr leaves the pin unchanged
    run_combo(3'b000, 2'b01, 8'h10);
    @(negedge clk);
    held = pv_a;
    tick = 1'b0; evt_top = 1'b0; evt_wrap = 1'b0; cnt = ocr;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(pv_a, held, "R11");
    end
    tick = 1'b1;
    @(negedge clk);
    chk(pv_a, ~held, "R3");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule